// File: doc/BRIEF.md
# Shared RAM Access Address Pointer

This block holds the word pointer that an external host uses to reach a small on-chip shared RAM of 2 kbytes, organised as 512 words of 32 bits. The host loads the pointer and then reads or writes RAM words through a single-cycle data port. The pointer sits at a fixed position inside a 32-bit read-back value. The local CPU can see that value but cannot change it.

With continuous-access mode enabled, every host RAM access moves the pointer by one word after the access. A direction input selects whether it moves up (+4 bytes) or down (-4 bytes). The 9-bit word address wraps at both ends of the space, so streams of back-to-back accesses reach consecutive words. With the mode disabled, the host can access the same word repeatedly.

One pointer write port serves both agents. A source flag marks each write as coming from the host or from the local CPU, and only host writes take effect.

Top module: `shram_ptr`

## Requirements
- R1: The pointer read-back `ptr_rdata` is 32 bits wide. The word address is held in bits 10 down to 2, so the byte address equals the word address times 4.
- R2: Bits 31 to 11 and bits 1 to 0 of `ptr_rdata` always read as zero. Any value written to those bit positions of `ptr_wdata` has no effect.
- R3: After reset, `ptr_rdata` is 0 and `acc_rvalid` is 0.
- R4: A pointer write with `ptr_wr_host`=1 loads `ptr_wdata[10:2]` into the pointer, visible on the next cycle. A pointer write with `ptr_wr_host`=0 (local CPU) leaves the pointer unchanged.
- R5: While `seq_en`=0, host accesses (`acc_en`=1) leave the pointer unchanged.
- R6: While `seq_en`=1 and `step_down`=0, each host access increments the byte pointer by 4 on the clock edge that completes the access.
- R7: While `seq_en`=1 and `step_down`=1, each host access decrements the byte pointer by 4 on the clock edge that completes the access.
- R8: Stepping wraps within the space in both directions: 0x7FC steps up to 0x000, and 0x000 steps down to 0x7FC.
- R9: If a host pointer write and an access-driven step fall in the same cycle, the pointer takes the written value. The access itself still uses the pointer as it was before that edge.
- R10: An access with `acc_we`=1 stores `acc_wdata` at the current word. An access with `acc_we`=0 returns the word at the current pointer on `acc_rdata` one cycle later, with `acc_rvalid` high for exactly that cycle. Accesses on back-to-back cycles reach consecutive words when stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wr_host | input | 1 | Write source: 1 host, 0 local CPU |
| ptr_wdata | input | 32 | Pointer write value (byte address form) |
| seq_en | input | 1 | Continuous-access mode: step after each access |
| step_down | input | 1 | Step direction: 0 up by 4, 1 down by 4 |
| acc_en | input | 1 | Host RAM access strobe |
| acc_we | input | 1 | Access type: 1 write, 0 read |
| acc_wdata | input | 32 | Host RAM write data |
| acc_rdata | output | 32 | Host RAM read data |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read access |
| ptr_rdata | output | 32 | Pointer read-back |

## Verification
The hardest case to reach is a host pointer write that lands on the same edge as an access-driven step. In that case the write must win, while the read data still comes from the old word. The stimulus first parks the pointer on a known word. It then issues a read with stepping enabled and a host pointer load in the same cycle, and checks both the new pointer and the returned word. Both wrap corners are also driven on purpose: the pointer is loaded to 0x7FC and stepped up, then stepped down from 0x000, and the words written across each boundary are read back.

// File: rtl/shram_pkg.sv
package shram_pkg;

   typedef enum logic {
      STEP_UP   = 1'b0,
      STEP_DOWN = 1'b1
   } step_dir_e;

   typedef struct packed {
      logic      seq;
      step_dir_e dir;
      logic      acc;
   } step_ctl_t;

endpackage

// File: rtl/shram_ptr_step.sv
module shram_ptr_step #(
   parameter int AW = 9
) (
   input  logic [AW-1:0]        cur,
   input  shram_pkg::step_ctl_t ctl,
   output logic [AW-1:0]        nxt,
   output logic                 moves
);
   import shram_pkg::*;

   always_comb begin
      moves = ctl.acc & ctl.seq;
      if (!moves)
         nxt = cur;
      else if (ctl.dir == STEP_DOWN)
         nxt = cur - AW'(1);
      else
         nxt = cur + AW'(1);
   end

endmodule

// File: rtl/shram_ptr_reg.sv
module shram_ptr_reg #(
   parameter int REG_W = 32,
   parameter int AW    = 9,
   parameter int LSB   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wr_host,
   input  logic [REG_W-1:0] wdata,
   input  logic [AW-1:0]    step_nxt,
   input  logic             step_moves,
   output logic [AW-1:0]    word_ptr,
   output logic [REG_W-1:0] rd_view
);
   localparam int MSB = LSB + AW - 1;

   logic          load;
   logic [AW-1:0] ptr_q;
   logic          unused_wbits;

   assign load = wr & wr_host;

   generate
      if (MSB < REG_W - 1 && LSB > 0) begin : g_both_pad
         assign unused_wbits = ^{wdata[REG_W-1:MSB+1], wdata[LSB-1:0]};
      end else if (MSB < REG_W - 1) begin : g_hi_pad
         assign unused_wbits = ^wdata[REG_W-1:MSB+1];
      end else if (LSB > 0) begin : g_lo_pad
         assign unused_wbits = ^wdata[LSB-1:0];
      end else begin : g_no_pad
         assign unused_wbits = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (load)
         ptr_q <= wdata[MSB:LSB];
      else if (step_moves)
         ptr_q <= step_nxt;
   end

   assign word_ptr = ptr_q;

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_view
         if (b >= LSB && b <= MSB) begin : g_live
            assign rd_view[b] = ptr_q[b-LSB];
         end else begin : g_zero
            assign rd_view[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/shram_word_ram.sv
module shram_word_ram #(
   parameter int DW    = 32,
   parameter int WORDS = 512,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (en && we)
         mem[addr] <= wdata;
      if (en && !we)
         rdata_q <= mem[addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rvalid <= 1'b0;
      else
         rvalid <= en & ~we;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/shram_ptr.sv
module shram_ptr #(
   parameter int SPACE_BYTES = 2048,
   parameter int DATA_W      = 32,
   parameter int REG_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic              ptr_wr_host,
   input  logic [REG_W-1:0]  ptr_wdata,
   input  logic              seq_en,
   input  logic              step_down,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_rvalid,
   output logic [REG_W-1:0]  ptr_rdata
);
   import shram_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WORDS      = SPACE_BYTES / WORD_BYTES;
   localparam int AW         = $clog2(WORDS);
   localparam int LSB        = $clog2(WORD_BYTES);

   generate
      if (DATA_W % 8 != 0 || (1 << LSB) != WORD_BYTES) begin : g_bad_dw
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if ((1 << AW) != WORDS) begin : g_bad_space
         $error("SPACE_BYTES must give a power-of-two word count");
      end
      if (LSB + AW > REG_W) begin : g_bad_reg
         $error("REG_W too narrow for the address space");
      end
   endgenerate

   step_ctl_t     ctl;
   logic [AW-1:0] word_ptr;
   logic [AW-1:0] step_nxt;
   logic          step_moves;

   assign ctl.seq = seq_en;
   assign ctl.dir = step_down ? STEP_DOWN : STEP_UP;
   assign ctl.acc = acc_en;

   shram_ptr_step #(.AW(AW)) u_step (
      .cur   (word_ptr),
      .ctl   (ctl),
      .nxt   (step_nxt),
      .moves (step_moves)
   );

   shram_ptr_reg #(.REG_W(REG_W), .AW(AW), .LSB(LSB)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ptr_wr),
      .wr_host    (ptr_wr_host),
      .wdata      (ptr_wdata),
      .step_nxt   (step_nxt),
      .step_moves (step_moves),
      .word_ptr   (word_ptr),
      .rd_view    (ptr_rdata)
   );

   shram_word_ram #(.DW(DATA_W), .WORDS(WORDS), .AW(AW)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (acc_en),
      .we     (acc_we),
      .addr   (word_ptr),
      .wdata  (acc_wdata),
      .rdata  (acc_rdata),
      .rvalid (acc_rvalid)
   );

endmodule

// File: rtl/shram_ptr_chk.sv
module shram_ptr_chk #(
   parameter int REG_W = 32,
   parameter int AW    = 9,
   parameter int LSB   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ptr_wr,
   input logic             ptr_wr_host,
   input logic [REG_W-1:0] ptr_wdata,
   input logic             seq_en,
   input logic             step_down,
   input logic             acc_en,
   input logic             acc_we,
   input logic             acc_rvalid,
   input logic [REG_W-1:0] ptr_rdata
);
   localparam int MSB = LSB + AW - 1;
   localparam logic [REG_W-1:0] LIVE = ((REG_W'(1) << AW) - REG_W'(1)) << LSB;

   logic          host_ld;
   logic [AW-1:0] wp;
   logic [AW-1:0] wv;
   assign host_ld = ptr_wr & ptr_wr_host;
   assign wp      = ptr_rdata[MSB:LSB];
   assign wv      = ptr_wdata[MSB:LSB];

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rdata & ~LIVE) == '0);

   a_r4_host_load: assert property (@(posedge clk) disable iff (!rst_n)
      host_ld |=> wp == $past(wv));

   a_r4_cpu_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && !ptr_wr_host && !acc_en) |=> $stable(ptr_rdata));

   a_r5_no_step_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !seq_en && !host_ld) |=> $stable(ptr_rdata));

   a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && seq_en && !step_down && !host_ld) |=> wp == AW'($past(wp) + AW'(1)));

   a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && seq_en && step_down && !host_ld) |=> wp == AW'($past(wp) - AW'(1)));

   a_r8_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && seq_en && !step_down && !host_ld && (&wp)) |=> wp == '0);

   a_r8_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && seq_en && step_down && !host_ld && wp == '0) |=> (&wp));

   a_r10_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_we) |=> acc_rvalid);

   a_r10_rvalid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && !acc_we) |=> !acc_rvalid);

endmodule

bind shram_ptr shram_ptr_chk #(.REG_W(REG_W), .AW(AW), .LSB(LSB)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ptr_wr      (ptr_wr),
   .ptr_wr_host (ptr_wr_host),
   .ptr_wdata   (ptr_wdata),
   .seq_en      (seq_en),
   .step_down   (step_down),
   .acc_en      (acc_en),
   .acc_we      (acc_we),
   .acc_rvalid  (acc_rvalid),
   .ptr_rdata   (ptr_rdata)
);

// File: tb/shram_ptr_test.sv
module shram_ptr_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_wr = 1'b0;
   logic        ptr_wr_host = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        seq_en = 1'b0;
   logic        step_down = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_we = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        acc_rvalid;
   logic [31:0] ptr_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] model [512];
   logic [8:0]  exp_wp = '0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   string       cur_tag = "R10";

   always #5 clk = ~clk;

   shram_ptr uut (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wr_host(ptr_wr_host),
      .ptr_wdata(ptr_wdata), .seq_en(seq_en), .step_down(step_down),
      .acc_en(acc_en), .acc_we(acc_we), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .ptr_rdata(ptr_rdata)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at a falling edge and update the model.
   task automatic op(input bit acc, input bit we, input logic [31:0] wd,
                     input bit pw, input bit host, input logic [31:0] pwd);
      logic [8:0] nxt;
      acc_en = acc; acc_we = we; acc_wdata = wd;
      ptr_wr = pw; ptr_wr_host = host; ptr_wdata = pwd;
      nxt = exp_wp;
      if (acc) begin
         if (we) model[exp_wp] = wd;
         else begin
            exp_q.push_back(model[exp_wp]);
            tag_q.push_back(cur_tag);
         end
         if (seq_en) nxt = step_down ? exp_wp - 9'd1 : exp_wp + 9'd1;
      end
      if (pw && host) nxt = pwd[10:2];
      exp_wp = nxt;
      @(negedge clk);
   endtask

   task automatic idle();
      acc_en = 1'b0; acc_we = 1'b0; ptr_wr = 1'b0; ptr_wr_host = 1'b0;
   endtask

   task automatic check_ptr(input string tag);
      logic [31:0] e;
      e = {21'b0, exp_wp, 2'b00};
      check(ptr_rdata === e, tag, ptr_rdata, e);
   endtask

   task automatic hload(input logic [31:0] v);
      op(1'b0, 1'b0, '0, 1'b1, 1'b1, v);
      idle();
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done && acc_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected rvalid", acc_rdata, '0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(acc_rdata === e, t, acc_rdata, e);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(ptr_rdata === 32'h0, "R3 reset pointer", ptr_rdata, 32'h0);
      check(acc_rvalid === 1'b0, "R3 reset rvalid", {31'b0, acc_rvalid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: local CPU write ignored
      op(1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h0000_0123);
      idle();
      check_ptr("R4 cpu write ignored");

      // R1 R2: reserved bits dropped
      hload(32'hFFFF_F7FF);
      check_ptr("R2 reserved bits read zero");
      check(ptr_rdata === 32'h0000_07FC, "R1 word field", ptr_rdata, 32'h7FC);

      hload(32'h0000_0010);
      check_ptr("R4 host load");

      // R5: no stepping with lock clear
      seq_en = 1'b0;
      op(1'b1, 1'b1, 32'hA5A5_0001, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R5 write no step");
      cur_tag = "R5 R10 read same word";
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R5 read no step");

      // R6: stepping up, back-to-back writes then reads
      seq_en = 1'b1; step_down = 1'b0;
      op(1'b1, 1'b1, 32'hB000_000B, 1'b0, 1'b0, '0);
      op(1'b1, 1'b1, 32'hC000_000C, 1'b0, 1'b0, '0);
      op(1'b1, 1'b1, 32'hD000_000D, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R6 step up writes");
      hload(32'h0000_0010);
      cur_tag = "R6 R10 back-to-back read up";
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R6 step up reads");

      // R7: stepping down
      step_down = 1'b1;
      hload(32'h0000_0018);
      cur_tag = "R7 R10 back-to-back read down";
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R7 step down");

      // R8: wrap at both ends
      step_down = 1'b0;
      hload(32'h0000_07FC);
      op(1'b1, 1'b1, 32'hE000_000E, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R8 wrap up to zero");
      check(ptr_rdata === 32'h0, "R8 wrap up value", ptr_rdata, 32'h0);
      step_down = 1'b1;
      op(1'b1, 1'b1, 32'hF000_000F, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R8 wrap down to top");
      check(ptr_rdata === 32'h7FC, "R8 wrap down value", ptr_rdata, 32'h7FC);
      cur_tag = "R8 R10 read across wrap";
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      op(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      idle();
      check_ptr("R8 read down");

      // R9: host load wins over step in the same cycle
      step_down = 1'b0;
      hload(32'h0000_0010);
      cur_tag = "R9 read uses old pointer";
      op(1'b1, 1'b0, '0, 1'b1, 1'b1, 32'h0000_0040);
      idle();
      check_ptr("R9 load wins over step");
      check(ptr_rdata === 32'h40, "R9 value", ptr_rdata, 32'h40);

      // R4: CPU write during a step does not disturb stepping
      op(1'b1, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 32'h0000_0100);
      idle();
      check_ptr("R4 cpu write during step");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule